// File: doc/BRIEF.md
# Second-Order Cascaded Noise-Shaping Modulator

This block turns a wide signed sample stream into a coarse multi-level word every clock. Inside are two first-order digital modulators. The first one quantizes the input sample. The residue it leaves behind, which is its accumulator value minus the level it emitted, becomes the input of the second one. A small recombination stage delays the first modulator's level by one cycle. It passes the second modulator's level through a first difference and adds the two results. The residue of the first modulator then drops out of the sum. What remains in the output is the second modulator's error, shaped to second order.

The output word can take more than two values. It is meant for a fast few-level converter that follows the block. Upsampling ahead of the block is not part of this design, and neither is any conversion after it. The block takes one input sample per clock and produces one output value per clock, with no flow control.

Top module: `mash2_mod`

## Requirements
- R1: While `rst` is high at a clock edge, `y_out` reads 0 after that edge. Reset also clears both accumulators and both delayed-level registers.
- R2: From the first clock edge after reset is released, `y_out` is a 3-bit two's-complement value. It is always one of -3, -1, +1 or +3.
- R3: Each modulator emits level +1 when its accumulator is zero or positive, and level -1 when the accumulator is negative. Because both accumulators start from zero, the first output after reset is +1.
- R4: The full-scale unit is FS = 2^(DW-1). Each modulator's accumulator grows by its input minus its level times FS. The second modulator's input is the first accumulator minus the first level times FS.
- R5: At every clock edge, `y_out` becomes the sum of three terms: the first modulator's level from the previous cycle, plus the second modulator's current level, minus the second modulator's level from the previous cycle. The delayed levels are 0 straight after reset.
- R6: With a constant input x held for M cycles, |FS·Σy_out − M·x| stays at or below 8·FS.
- R7: The second modulator's input always stays within [-FS, FS).
- R8: For every input in [-FS, FS-1], including both extremes held indefinitely, each accumulator stays within [-2FS, 2FS). It never wraps.
- R9: A slow ramp across the input range drives `y_out` through at least three distinct values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | DW | Signed input sample, two's complement |
| y_out | output | 3 | Signed registered output level, in units of FS |

## Verification
The output reaches ±3 only when two things line up in the same cycle. The delayed first-stage level must have the same sign as the step in the second-stage level, and that step must be a full swing. The bench provokes this overlap with inputs held near both full-scale limits and with a slow ramp. It judges every such cycle against an unbounded integer model built from R3, R4 and R5. A second overlap is a reset that arrives while the delayed-level registers hold nonzero values. The bench re-applies reset in the middle of a run and expects the following output to restart exactly at +1.

// File: rtl/mash2_pkg.sv
package mash2_pkg;
  typedef logic signed [2:0] lvl_t;
  localparam lvl_t LVL_POS  = 3'sd1;
  localparam lvl_t LVL_NEG  = -3'sd1;
  localparam lvl_t LVL_NONE = 3'sd0;
endpackage

// File: rtl/mash2_stage.sv
module mash2_stage
  import mash2_pkg::*;
#(
  parameter int AW      = 14,
  parameter int FS_LOG2 = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [AW-1:0] u,
  output lvl_t                 lvl,
  output logic signed [AW-1:0] err
);
  localparam int                 FS_I  = 1 << FS_LOG2;
  localparam logic signed [AW-1:0] FS  = AW'(FS_I);
  localparam logic signed [AW-1:0] FS2 = AW'(2 * FS_I);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] fb;

  // sign quantizer: zero counts as positive
  assign lvl = acc[AW-1] ? LVL_NEG : LVL_POS;
  assign fb  = acc[AW-1] ? -FS : FS;
  assign err = acc - fb;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + u - fb;
  end

  // R7: residue handed onward stays inside one full-scale span
  assert_err_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (err >= -FS) && (err < FS));

  // R8: accumulator never leaves its two-full-scale window
  assert_acc_span_R8: assert property (@(posedge clk) disable iff (rst)
    (acc >= -FS2) && (acc <= FS2 - AW'(1)));
endmodule

// File: rtl/mash2_recomb.sv
module mash2_recomb
  import mash2_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t l1,
  input  lvl_t l2,
  output lvl_t y_out
);
  lvl_t l1_dly;
  lvl_t l2_dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_dly <= LVL_NONE;
      l2_dly <= LVL_NONE;
      y_out  <= LVL_NONE;
    end else begin
      l1_dly <= l1;
      l2_dly <= l2;
      y_out  <= l1_dly + l2 - l2_dly;
    end
  end

  // R1: output cleared one edge after reset is seen
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (y_out == LVL_NONE));

  // R2: once running, only odd levels within +/-3 appear
  assert_out_odd_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (y_out[0] && (y_out != -3'sd4)));
endmodule

// File: rtl/mash2_mod.sv
module mash2_mod
  import mash2_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x_in,
  output logic signed [2:0]    y_out
);
  localparam int AW      = DW + 2;
  localparam int FS_LOG2 = DW - 1;

  logic signed [AW-1:0] u1;
  logic signed [AW-1:0] e1;
  logic signed [AW-1:0] e2;
  lvl_t                 l1;
  lvl_t                 l2;
  lvl_t                 y_lvl;

  assign u1 = AW'(x_in);

  mash2_stage #(.AW(AW), .FS_LOG2(FS_LOG2)) u_st1 (
    .clk(clk), .rst(rst), .u(u1), .lvl(l1), .err(e1)
  );

  mash2_stage #(.AW(AW), .FS_LOG2(FS_LOG2)) u_st2 (
    .clk(clk), .rst(rst), .u(e1), .lvl(l2), .err(e2)
  );

  mash2_recomb u_rc (
    .clk(clk), .rst(rst), .l1(l1), .l2(l2), .y_out(y_lvl)
  );

  assign y_out = y_lvl;

  logic unused_e2;
  assign unused_e2 = ^e2;
endmodule

// File: tb/mash2_mod_test.sv
module mash2_mod_test;
  localparam int DW = 12;
  localparam int FS = 1 << (DW - 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [DW-1:0] x_in = '0;
  logic signed [2:0]    y_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, from the requirement equations
  int a1, a2, l1d, l2d, mout;

  mash2_mod #(.DW(DW)) uut (.clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int a);
    return (a >= 0) ? 1 : -1;
  endfunction

  task automatic step(input int x);
    int l1, l2, e1, e2;
    x_in = DW'(x);
    l1 = sgn(a1);
    e1 = a1 - l1 * FS;
    l2 = sgn(a2);
    e2 = a2 - l2 * FS;
    mout = l1d + l2 - l2d;
    a1 = a1 + x - l1 * FS;
    a2 = a2 + e1 - l2 * FS;
    l1d = l1;
    l2d = l2;
    chk((e1 >= -FS) && (e1 < FS), "R7 model residue", e1, 0);
    @(negedge clk);
    chk(int'(y_out) == mout, "R4 R5 exact output", int'(y_out), mout);
    chk(y_out[0] == 1'b1, "R2 odd level", int'(y_out), mout);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst  = 1'b1;
    x_in = '0;
    repeat (3) @(negedge clk);
    chk(int'(y_out) == 0, "R1 reset output", int'(y_out), 0);
    a1 = 0; a2 = 0; l1d = 0; l2d = 0; mout = 0;
    rst = 1'b0;
  endtask

  task automatic t_first_level();
    do_reset();
    step(-100);
    chk(int'(y_out) == 1, "R3 first level after reset", int'(y_out), 1);
  endtask

  task automatic t_dc(input int x);
    longint sy;
    longint diff;
    do_reset();
    for (int i = 0; i < 16; i++) step(x);
    sy = 0;
    for (int i = 0; i < 2048; i++) begin
      step(x);
      sy += int'(y_out);
    end
    diff = sy * FS - longint'(2048) * x;
    if (diff < 0) diff = -diff;
    chk(diff <= 8 * FS, "R6 dc mean", int'(diff), 8 * FS);
  endtask

  task automatic t_fullscale();
    int mn, mx;
    do_reset();
    for (int i = 0; i < 600; i++) step(FS - 1);
    for (int i = 0; i < 600; i++) step(-FS);
    for (int i = 0; i < 200; i++) step((i % 2) ? (FS - 1) : -FS);
    mn = (a1 < a2) ? a1 : a2;
    mx = (a1 > a2) ? a1 : a2;
    chk((mn >= -2 * FS) && (mx < 2 * FS), "R8 accumulator span", mx, 2 * FS);
  endtask

  task automatic t_ramp();
    bit [7:0] seen;
    int cnt;
    seen = '0;
    do_reset();
    for (int i = 0; i < 4096; i++) begin
      step(-FS + (i * (2 * FS - 1)) / 4096);
      seen[int'(y_out) + 3] = 1'b1;
    end
    cnt = $countones(seen);
    chk(cnt >= 3, "R9 distinct levels", cnt, 3);
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 37; i++) step(FS / 3);
    do_reset();
    step(FS / 2);
    chk(int'(y_out) == 1, "R1 R3 restart after mid-run reset", int'(y_out), 1);
    for (int i = 0; i < 50; i++) step(-FS / 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_first_level();
    t_dc(0);
    t_dc(FS / 3);
    t_dc(-(3 * FS) / 4);
    t_dc(FS - 1);
    t_fullscale();
    t_ramp();
    t_midreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule